// File: doc/BRIEF.md
# Dual Digital Phase Detector

This block holds two phase comparators for an all-digital loop. Both sample their inputs with a fast system clock. The feedback signal `fb` is shared between them. The quadrature comparator drives `xor_out`, which is high whenever `ref_a1` and `fb` disagree. Its zero-error point is a quarter-cycle offset between the two inputs, and its gain is 4, so it saturates at a quarter-cycle error. The transition comparator drives `ecpd_out`. A falling edge on `ref_a2` sets it and a falling edge on `fb` clears it. Its zero-error point is a half-cycle offset, and its gain is 2, so it saturates at a half-cycle error. At zero error, each comparator produces a square wave with equal high and low times.

The input `sel_edge` picks which comparator steers `dn_up`, the count-direction line that feeds an external loop counter. Every asynchronous input first passes through a synchronizer of `SYNC_STAGES` flops. The transition comparator can take one extra retiming stage, set by `EDGE_EXTRA_STAGE`, which is on by default. The quadrature comparator reaches its full lock range only when both of its inputs have a 50% duty factor. The loop filter, the counters and the frequency synthesis sit outside the block.

Top module: `dual_phase_detector`

## Requirements
- R1: Once the inputs have been steady for three clocks, `xor_out` equals `ref_a1` XOR `fb`. It is 0 when the two are equal and 1 when they differ.
- R2: A falling edge on `ref_a2` alone drives `ecpd_out` to 1.
- R3: A falling edge on `fb` alone drives `ecpd_out` to 0.
- R4: `ecpd_out` keeps its value when neither `ref_a2` nor `fb` has a falling edge. This covers steady inputs and rising edges.
- R5: When falling edges on `ref_a2` and `fb` land in the same clock, `ecpd_out` inverts.
- R6: With `sel_edge` = 0, `dn_up` follows `xor_out`. With `sel_edge` = 1, `dn_up` follows `ecpd_out`. The change takes effect in the same cycle.
- R7: While `rst_n` is low at a clock edge, `xor_out`, `ecpd_out` and `dn_up` go to 0.
- R8: An input change set up before clock edge t reaches `xor_out` after edge t+2. With the default extra stage it reaches `ecpd_out` after edge t+3.
- R9: Consider square waves of period 16 clocks. When `ref_a1` leads `fb` by 4 clocks, `xor_out` is high for 32 of any 64 consecutive cycles. When `ref_a2` leads `fb` by 8 clocks, `ecpd_out` is high for 32 of any 64 consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Synchronous reset, active low |
| ref_a1 | input | 1 | Reference for the quadrature comparator (asynchronous) |
| ref_a2 | input | 1 | Reference for the transition comparator (asynchronous) |
| fb | input | 1 | Shared feedback input (asynchronous) |
| sel_edge | input | 1 | 0 = `dn_up` from `xor_out`, 1 = `dn_up` from `ecpd_out` |
| xor_out | output | 1 | Quadrature comparator output |
| ecpd_out | output | 1 | Transition comparator output |
| dn_up | output | 1 | Selected count-direction control |

## Verification
The transition comparator's only hidden state is its output flop and the previous-sample registers. A corrupted previous sample shows up as a spurious or missed set, clear or toggle on `ecpd_out` within one cycle of the affected edge. A wrong synchronizer depth, or a missing extra stage, shifts `xor_out` or `ecpd_out` by a whole clock, so the edge-exact latency checks catch it. A duty-count error in the phase tests shows a bad zero-error point within one 16-cycle period.

// File: rtl/pd_pkg.sv
// Shared types for the dual phase detector.
// Assumes: the select encoding below is the one the top-level port carries.
package pd_pkg;
    typedef enum logic {
        SRC_QUAD = 1'b0,
        SRC_EDGE = 1'b1
    } pd_src_e;

    localparam int unsigned MIN_SYNC_STAGES = 2;
endpackage

// File: rtl/pd_sync.sv
// Multi-flop synchronizer for one asynchronous level.
// Assumes: STAGES >= 2; reset value of every stage is 0.
module pd_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    // Shift the input through the stages.
    always_ff @(posedge clk) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[STAGES-2:0], d};
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/pd_quad_det.sv
// Exclusive-OR phase comparator with a registered output.
// Assumes: both inputs are already synchronous to clk.
module pd_quad_det (
    input  logic clk,
    input  logic rst_n,
    input  logic a,
    input  logic b,
    output logic y
);
    // Register the disagreement of the two inputs.
    always_ff @(posedge clk) begin
        if (!rst_n) y <= 1'b0;
        else        y <= a ^ b;
    end
endmodule

// File: rtl/pd_edge_det.sv
// Falling-edge set/reset comparator with JK behaviour on simultaneous edges.
// Assumes: inputs are synchronous; EXTRA != 0 inserts one retiming stage.
module pd_edge_det #(
    parameter bit EXTRA = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic set_in,
    input  logic clr_in,
    output logic q,
    output logic fall_set,
    output logic fall_clr
);
    logic set_cur, clr_cur;
    logic set_prev, clr_prev;

    generate
        if (EXTRA) begin : g_retime
            logic set_d, clr_d;
            // Optional extra pipeline stage ahead of edge detection.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    set_d <= 1'b0;
                    clr_d <= 1'b0;
                end else begin
                    set_d <= set_in;
                    clr_d <= clr_in;
                end
            end
            assign set_cur = set_d;
            assign clr_cur = clr_d;
        end else begin : g_direct
            assign set_cur = set_in;
            assign clr_cur = clr_in;
        end
    endgenerate

    // Keep the previous sample of each input for edge comparison.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            set_prev <= 1'b0;
            clr_prev <= 1'b0;
        end else begin
            set_prev <= set_cur;
            clr_prev <= clr_cur;
        end
    end

    assign fall_set = set_prev & ~set_cur;
    assign fall_clr = clr_prev & ~clr_cur;

    // JK update: set, clear, toggle or hold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= 1'b0;
        end else begin
            unique case ({fall_set, fall_clr})
                2'b10:   q <= 1'b1;
                2'b01:   q <= 1'b0;
                2'b11:   q <= ~q;
                default: q <= q;
            endcase
        end
    end
endmodule

// File: rtl/dual_phase_detector.sv
// Top: two phase comparators sharing the feedback input, plus an output select.
// Assumes: ref_a1, ref_a2 and fb are asynchronous; sel_edge is synchronous.
module dual_phase_detector
    import pd_pkg::*;
#(
    parameter int unsigned SYNC_STAGES      = 2,
    parameter bit          EDGE_EXTRA_STAGE = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ref_a1,
    input  logic ref_a2,
    input  logic fb,
    input  logic sel_edge,
    output logic xor_out,
    output logic ecpd_out,
    output logic dn_up
);
    localparam int unsigned NUM_IN = 3;
    localparam int unsigned DEPTH  = (SYNC_STAGES < MIN_SYNC_STAGES) ? MIN_SYNC_STAGES : SYNC_STAGES;

    logic [NUM_IN-1:0] raw_in, syn_in;
    logic              ecpd_fall_ref, ecpd_fall_fb;
    pd_src_e           src;

    assign raw_in = {fb, ref_a2, ref_a1};

    generate
        for (genvar gi = 0; gi < NUM_IN; gi++) begin : g_sync
            pd_sync #(.STAGES(DEPTH)) i_sync (
                .clk  (clk),
                .rst_n(rst_n),
                .d    (raw_in[gi]),
                .q    (syn_in[gi])
            );
        end
    endgenerate

    pd_quad_det i_quad (
        .clk  (clk),
        .rst_n(rst_n),
        .a    (syn_in[0]),
        .b    (syn_in[2]),
        .y    (xor_out)
    );

    pd_edge_det #(.EXTRA(EDGE_EXTRA_STAGE)) i_edge (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_in  (syn_in[1]),
        .clr_in  (syn_in[2]),
        .q       (ecpd_out),
        .fall_set(ecpd_fall_ref),
        .fall_clr(ecpd_fall_fb)
    );

    // Choose which comparator steers the loop counter.
    assign src   = pd_src_e'(sel_edge);
    assign dn_up = (src == SRC_EDGE) ? ecpd_out : xor_out;
endmodule

// File: rtl/pd_checker.sv
// Property checker for dual_phase_detector, attached by bind.
// Assumes: default synchronizer depth of 2 for the latency property.
module pd_checker (
    input logic clk,
    input logic rst_n,
    input logic ref_a1,
    input logic fb,
    input logic xor_out,
    input logic ecpd_out,
    input logic fall_set,
    input logic fall_clr
);
    logic [1:0] since_rst;

    // Count clocks since reset release, saturating at 3.
    always_ff @(posedge clk) begin
        if (!rst_n)              since_rst <= 2'd0;
        else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
    end

    p_xor_track_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst == 2'd3) |-> (xor_out == ($past(ref_a1, 3) ^ $past(fb, 3))));

    p_edge_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (fall_set && !fall_clr) |=> ecpd_out);

    p_edge_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (fall_clr && !fall_set) |=> !ecpd_out);

    p_edge_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!fall_set && !fall_clr) |=> $stable(ecpd_out));

    p_edge_toggle_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (fall_set && fall_clr) |=> (ecpd_out != $past(ecpd_out)));

    p_reset_low_r7: assert property (@(posedge clk)
        !rst_n |=> (!xor_out && !ecpd_out));
endmodule

bind dual_phase_detector pd_checker i_pd_checker (
    .clk     (clk),
    .rst_n   (rst_n),
    .ref_a1  (ref_a1),
    .fb      (fb),
    .xor_out (xor_out),
    .ecpd_out(ecpd_out),
    .fall_set(ecpd_fall_ref),
    .fall_clr(ecpd_fall_fb)
);

// File: tb/test_dual_phase_detector.sv
`timescale 1ns/1ps
module test_dual_phase_detector;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ref_a1 = 1'b0, ref_a2 = 1'b0, fb = 1'b0, sel_edge = 1'b0;
    logic xor_out, ecpd_out, dn_up;
    int   n_tests = 0;
    int   n_fail  = 0;
    bit   done    = 1'b0;

    always #2 clk = ~clk;

    dual_phase_detector i_dual_phase_detector (
        .clk(clk), .rst_n(rst_n), .ref_a1(ref_a1), .ref_a2(ref_a2), .fb(fb),
        .sel_edge(sel_edge), .xor_out(xor_out), .ecpd_out(ecpd_out), .dn_up(dn_up)
    );

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: got %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic t_reset;
        ref_a1 = 1'b1; fb = 1'b0; ref_a2 = 1'b1; sel_edge = 1'b0;
        rst_n = 1'b0;
        step(6);
        chk("R7 xor_out in reset", xor_out, 0);
        chk("R7 ecpd_out in reset", ecpd_out, 0);
        chk("R7 dn_up in reset", dn_up, 0);
        ref_a1 = 1'b0; ref_a2 = 1'b0;
        rst_n = 1'b1;
        step(6);
    endtask

    task automatic t_xor_truth;
        for (int v = 0; v < 4; v++) begin
            ref_a1 = v[0]; fb = v[1];
            step(3);
            chk("R1 xor truth", xor_out, v[0] ^ v[1]);
        end
        ref_a1 = 1'b0; fb = 1'b0;
        step(4);
        ref_a1 = 1'b1;
        step(2);
        chk("R8 xor not before edge t+2", xor_out, 0);
        step(1);
        chk("R8 xor after edge t+2", xor_out, 1);
        ref_a1 = 1'b0;
        step(4);
    endtask

    task automatic t_edge;
        ref_a2 = 1'b1; fb = 1'b1;
        step(6);
        chk("R4 rising edges ignored", ecpd_out, 0);
        ref_a2 = 1'b0;
        step(3);
        chk("R8 ecpd not before edge t+3", ecpd_out, 0);
        step(1);
        chk("R2 fall on ref_a2 sets (R8 edge t+3)", ecpd_out, 1);
        fb = 1'b0;
        step(4);
        chk("R3 fall on fb clears", ecpd_out, 0);
        fb = 1'b1;
        step(6);
        chk("R4 rising fb no effect", ecpd_out, 0);
        ref_a2 = 1'b1;
        step(6);
        ref_a2 = 1'b0;
        step(6);
        chk("R2 set again", ecpd_out, 1);
        ref_a2 = 1'b1;
        step(8);
        chk("R4 steady/rising hold high", ecpd_out, 1);
        ref_a2 = 1'b0; fb = 1'b0;
        step(6);
        chk("R5 simultaneous falls toggle 1->0", ecpd_out, 0);
        ref_a2 = 1'b1; fb = 1'b1;
        step(6);
        ref_a2 = 1'b0; fb = 1'b0;
        step(6);
        chk("R5 simultaneous falls toggle 0->1", ecpd_out, 1);
    endtask

    task automatic t_select;
        ref_a1 = 1'b0; fb = 1'b0;
        step(4);
        sel_edge = 1'b0;
        #1;
        chk("R6 sel=0 follows xor_out", dn_up, 0);
        sel_edge = 1'b1;
        #1;
        chk("R6 sel=1 follows ecpd_out", dn_up, 1);
        sel_edge = 1'b0;
        step(1);
    endtask

    task automatic t_duty;
        int hi_x = 0;
        int hi_e = 0;
        int hi_d = 0;
        sel_edge = 1'b1;
        for (int c = 0; c < 160; c++) begin
            @(negedge clk);
            if (c >= 96) begin
                hi_x += int'(xor_out);
                hi_e += int'(ecpd_out);
                hi_d += int'(dn_up);
            end
            fb     = (c % 16) < 8;
            ref_a1 = ((c + 4) % 16) < 8;
            ref_a2 = ((c + 8) % 16) < 8;
        end
        chk("R9 xor duty at quarter offset", hi_x, 32);
        chk("R9 ecpd duty at half offset", hi_e, 32);
        chk("R6 dn_up duty with sel=1", hi_d, 32);
    endtask

    initial begin
        t_reset();
        t_xor_truth();
        t_edge();
        t_select();
        t_duty();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule